// File: doc/BRIEF.md
# Modulo Timer with Capture/Compare Channels

A 16-bit timer peripheral. One up-counter advances on ticks from a power-of-two prescaler running off the bus clock. The counter either sweeps its whole range or wraps to zero after it reaches a programmable limit. Two channels share the counter. Software can set each channel, at run time, to snapshot the count when its input pin shows an edge, or to act on its output pin when the count reaches a stored value.

Software reaches the block through a byte-wide register bus with separate read and write strobes. Read data is registered and valid one cycle after the read strobe. A 16-bit value is written high byte first: the high byte waits in a holding register and both bytes take effect together when the low byte is written. Each event source has a sticky flag. The flags and their enables combine into one interrupt line.

Register addresses: 0 timer control, 1/2 count high/low, 3/4 limit high/low, 5 channel 0 setup, 6/7 channel 0 value high/low, 8 channel 1 setup, 9/10 channel 1 value high/low. Timer control bits: 7 overflow flag, 6 overflow interrupt enable, 5 halt, 4 clear (write-only), 2:0 prescale select. Channel setup bits: 7 flag, 6 interrupt enable, 5 compare mode (0 = capture), 4:3 pin action select, 2 toggle on wrap, 1 force high.

Top module: `tmr_cc_top`

## Requirements
- R1: After reset the control register reads 0x20 (halted, prescale 0), the count reads 0x0000, the limit reads 0xFFFF, both channel setups read 0x00, and irq, cmp_out and pin_oe are all low.
- R2: Prescale select n (0..6) advances the count once every 2^n running cycles, and select 7 behaves as select 6. While halted the prescaler makes no ticks.
- R3: While the halt bit is 1 the count and the prescaler hold their values.
- R4: Writing 1 to the clear bit (control bit 4) zeroes the count and the prescaler. The bit always reads back as 0.
- R5: On a tick where the count equals the limit, the count becomes 0x0000 and the overflow flag (control bit 7) sets.
- R6: A write to a high-byte address changes nothing visible. The 16-bit register updates only when its low byte is written, and then takes both bytes together.
- R7: In capture mode the pin action select picks the capturing edge (01 rising, 10 falling, 11 both, 00 none). The input passes through a two-flop synchronizer. On a selected edge the count is copied into the channel value and the channel flag (setup bit 7) sets. Edges that are not selected change nothing.
- R8: In compare mode, the tick on which the count becomes equal to the channel value sets the channel flag and acts on the pin: select 01 toggles it, 10 drives it low, 11 drives it high.
- R9: In compare mode, toggle-on-wrap (setup bit 2) inverts the pin on every counter wrap, and force-high (setup bit 1) holds cmp_out high while it is set.
- R10: A flag clears only when 0 is written to its bit after a read of that register showed the flag set. A write of 0 with no such read leaves the flag set.
- R11: irq is high when any flag is set together with its own interrupt enable.
- R12: pin_oe of a channel is high only in compare mode with a nonzero pin action select.
- R13: Reading the count does not change the count or the counting sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| cap_in | input | 2 | Channel input pins (capture mode) |
| cmp_out | output | 2 | Channel output pins (compare mode) |
| pin_oe | output | 2 | Per-channel pin drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler or counter state shows up as a count that is off by a predictable amount. The count is read while the counter is halted, a set number of cycles after it was started. A wrong wrap decision shows up on the next tick as an overflow flag, a pin toggle or a wrap-time count, and a wrong compare or capture decision is visible in the same way. A corrupted channel value or flag state shows up at the ports when the channel value or setup register is next read, within a few cycles of the stimulus: an unchanged value after an ignored edge, or a flag that clears without the read-then-write sequence.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

    localparam int CNT_W     = 16;
    localparam int PS_W      = 6;
    localparam int PS_MAX_SH = 6;
    localparam int REGS_PER_CH = 3;

    typedef enum logic [3:0] {
        A_CTRL  = 4'd0,
        A_CNTH  = 4'd1,
        A_CNTL  = 4'd2,
        A_LIMH  = 4'd3,
        A_LIML  = 4'd4,
        A_CH0   = 4'd5
    } reg_addr_e;

    typedef struct packed {
        logic       ie;
        logic       cmp;
        logic [1:0] act;
        logic       tov;
        logic       force_hi;
    } ch_cfg_t;

    typedef struct packed {
        logic       ovf_ie;
        logic       halt;
        logic [2:0] psel;
    } tctl_t;

    function automatic logic [PS_W-1:0] ps_mask(input logic [2:0] sel);
        logic [PS_W:0] one_hot;
        int sh;
        sh = (sel > 3'(PS_MAX_SH)) ? PS_MAX_SH : int'(sel);
        one_hot = (PS_W+1)'(1) << sh;
        return one_hot[PS_W-1:0] - PS_W'(1);
    endfunction

    function automatic logic [3:0] setup_addr(input int i);
        return 4'(int'(A_CH0) + REGS_PER_CH * i);
    endfunction

    function automatic logic [3:0] valh_addr(input int i);
        return 4'(int'(A_CH0) + REGS_PER_CH * i + 1);
    endfunction

    function automatic logic [3:0] vall_addr(input int i);
        return 4'(int'(A_CH0) + REGS_PER_CH * i + 2);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PS_W-1:0] div_q;
    logic [PS_W-1:0] mask;

    assign mask = ps_mask(sel);
    assign tick = run && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + PS_W'(1);
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);

    logic at_limit;

    assign at_limit = (cnt == limit);
    assign cnt_nxt  = at_limit ? '0 : cnt + CNT_W'(1);
    assign wrap     = tick && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_cc_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             wrap,
    input  logic             pin_in,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] val,
    output logic             flag,
    output logic             pin,
    output logic             oe
);

    logic [SYNC_N:0] sync_q;
    logic            cur_lvl, old_lvl, rise, fall;
    logic            cap_hit, cmp_hit;
    logic            pin_q, pin_d;

    assign cur_lvl = sync_q[SYNC_N-1];
    assign old_lvl = sync_q[SYNC_N];
    assign rise    = cur_lvl && !old_lvl;
    assign fall    = !cur_lvl && old_lvl;

    assign cap_hit = !cfg.cmp && ((cfg.act[0] && rise) || (cfg.act[1] && fall));
    assign cmp_hit = cfg.cmp && tick && (cnt_nxt == val);

    always_comb begin
        pin_d = pin_q;
        if (cmp_hit) begin
            case (cfg.act)
                2'b01:   pin_d = !pin_q;
                2'b10:   pin_d = 1'b0;
                2'b11:   pin_d = 1'b1;
                default: pin_d = pin_q;
            endcase
        end
        if (cfg.cmp && cfg.tov && wrap) begin
            pin_d = !pin_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            val    <= '0;
            flag   <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], pin_in};
            pin_q  <= pin_d;
            if (cap_hit) begin
                val <= cnt;
            end else if (load) begin
                val <= load_val;
            end
            if (cap_hit || cmp_hit) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end

    assign pin = cfg.cmp && (cfg.force_hi || pin_q);
    assign oe  = cfg.cmp && (cfg.act != 2'b00);

endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
    import tmr_cc_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int SYNC_N = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [3:0]     addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] cmp_out,
    output logic [NCH-1:0] pin_oe,
    output logic           irq
);

    tctl_t            ctl;
    logic             ovf_f, ovf_arm;
    logic [7:0]       hi_buf;
    logic [CNT_W-1:0] limit, cnt, cnt_nxt;
    logic             tick, wrap;
    logic             ctrl_wr, ctrl_clr, any_hi_wr;
    logic [7:0]       rd_mux;

    ch_cfg_t          cfg    [NCH];
    logic [CNT_W-1:0] ch_val [NCH];
    logic [NCH-1:0]   ch_flag, ch_arm, ch_clr, ch_load, setup_wr, cmp_mode;

    assign ctrl_wr  = wr_en && (addr == A_CTRL);
    assign ctrl_clr = ctrl_wr && wdata[4];

    tmr_prescale u_ps (
        .clk  (clk),
        .rst  (rst),
        .run  (!ctl.halt),
        .clr  (ctrl_clr),
        .sel  (ctl.psel),
        .tick (tick)
    );

    tmr_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .clr     (ctrl_clr),
        .limit   (limit),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    always_comb begin
        any_hi_wr = wr_en && (addr == A_LIMH);
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && (addr == valh_addr(i))) begin
                any_hi_wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '{ovf_ie: 1'b0, halt: 1'b1, psel: 3'd0};
            ovf_f   <= 1'b0;
            ovf_arm <= 1'b0;
            limit   <= '1;
            hi_buf  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctl.ovf_ie <= wdata[6];
                ctl.halt   <= wdata[5];
                ctl.psel   <= wdata[2:0];
            end
            if (any_hi_wr) begin
                hi_buf <= wdata;
            end
            if (wr_en && (addr == A_LIML)) begin
                limit <= {hi_buf, wdata};
            end
            if (wrap) begin
                ovf_f <= 1'b1;
            end else if (ctrl_wr && !wdata[7] && ovf_arm) begin
                ovf_f <= 1'b0;
            end
            if (ctrl_wr) begin
                ovf_arm <= 1'b0;
            end else if (rd_en && (addr == A_CTRL) && ovf_f) begin
                ovf_arm <= 1'b1;
            end
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        assign setup_wr[gi] = wr_en && (addr == setup_addr(gi));
        assign ch_load[gi]  = wr_en && (addr == vall_addr(gi));
        assign ch_clr[gi]   = setup_wr[gi] && !wdata[7] && ch_arm[gi];
        assign cmp_mode[gi] = cfg[gi].cmp;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[gi]    <= '0;
                ch_arm[gi] <= 1'b0;
            end else begin
                if (setup_wr[gi]) begin
                    cfg[gi] <= ch_cfg_t'(wdata[6:1]);
                end
                if (setup_wr[gi]) begin
                    ch_arm[gi] <= 1'b0;
                end else if (rd_en && (addr == setup_addr(gi)) && ch_flag[gi]) begin
                    ch_arm[gi] <= 1'b1;
                end
            end
        end

        tmr_channel #(.SYNC_N(SYNC_N)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg[gi]),
            .tick     (tick),
            .cnt      (cnt),
            .cnt_nxt  (cnt_nxt),
            .wrap     (wrap),
            .pin_in   (cap_in[gi]),
            .load     (ch_load[gi]),
            .load_val ({hi_buf, wdata}),
            .flag_clr (ch_clr[gi]),
            .val      (ch_val[gi]),
            .flag     (ch_flag[gi]),
            .pin      (cmp_out[gi]),
            .oe       (pin_oe[gi])
        );
    end

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL: rd_mux = {ovf_f, ctl.ovf_ie, ctl.halt, 2'b00, ctl.psel};
            A_CNTH: rd_mux = cnt[15:8];
            A_CNTL: rd_mux = cnt[7:0];
            A_LIMH: rd_mux = limit[15:8];
            A_LIML: rd_mux = limit[7:0];
            default: rd_mux = '0;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (addr == setup_addr(i)) rd_mux = {ch_flag[i], cfg[i], 1'b0};
            if (addr == valh_addr(i))  rd_mux = ch_val[i][15:8];
            if (addr == vall_addr(i))  rd_mux = ch_val[i][7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    always_comb begin
        irq = ovf_f && ctl.ovf_ie;
        for (int i = 0; i < NCH; i++) begin
            if (ch_flag[i] && cfg[i].ie) begin
                irq = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk
    import tmr_cc_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             halt,
    input logic             ctrl_wr,
    input logic             ctrl_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit,
    input logic             ovf_f,
    input logic             rd_en,
    input logic [3:0]       addr,
    input logic [7:0]       rdata,
    input logic [NCH-1:0]   cmp_mode,
    input logic [NCH-1:0]   pin_oe
);

    // R2: no prescaled tick while halted
    a_r2_no_tick_halted: assert property (@(posedge clk) disable iff (rst)
        halt |-> !tick);

    // R3: the count holds while halted
    a_r3_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (halt && !ctrl_wr) |=> $stable(cnt));

    // R4: the clear bit zeroes the count
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        ctrl_clr |=> (cnt == '0));

    // R4: the clear bit always reads back as zero
    a_r4_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && ($past(addr) == 4'd0)) |-> !rdata[4]);

    // R5: a tick at the limit wraps to zero and raises the overflow flag
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && (cnt == limit) && !ctrl_clr) |=> ((cnt == '0) && ovf_f));

    for (genvar gi = 0; gi < NCH; gi++) begin : g_oe
        // R12: a capture channel never drives its pin
        a_r12_oe_capture: assert property (@(posedge clk) disable iff (rst)
            !cmp_mode[gi] |-> !pin_oe[gi]);
    end

endmodule

bind tmr_cc_top tmr_cc_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .halt     (ctl.halt),
    .ctrl_wr  (ctrl_wr),
    .ctrl_clr (ctrl_clr),
    .cnt      (cnt),
    .limit    (limit),
    .ovf_f    (ovf_f),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .cmp_mode (cmp_mode),
    .pin_oe   (pin_oe)
);

// File: tb/tb_tmr_cc_top.sv
module tb_tmr_cc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] cap_in = '0;
    logic [1:0] cmp_out, pin_oe;
    logic       irq;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;
    bit  g_ie = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rv = 1'b0;

    always #10 clk = !clk;

    tmr_cc_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .cmp_out(cmp_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rv <= rd_en;
    always @(negedge clk) begin
        if (rv && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), int'(rdata), int'(exp_q.pop_front()));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: pushes the expected byte, then issues the read
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, input logic [15:0] e, input string tag);
        rd(a, e[15:8], tag);
        rd(a + 4'd1, e[7:0], tag);
    endtask

    function automatic logic [7:0] cb(input bit halt, input bit clr, input logic [2:0] ps);
        return {1'b0, g_ie, halt, clr, 1'b0, ps};
    endfunction

    task automatic clear_cnt(input logic [2:0] ps);
        wr(4'd0, cb(1'b1, 1'b1, ps));
    endtask

    // counter runs for exactly m clock edges
    task automatic run(input int m, input logic [2:0] ps);
        wr(4'd0, cb(1'b0, 1'b0, ps));
        repeat (m - 1) @(negedge clk);
        wr_en = 1'b1; addr = 4'd0; wdata = cb(1'b1, 1'b0, ps);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_limit(input logic [15:0] v);
        wr(4'd3, v[15:8]);
        wr(4'd4, v[7:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 cmp_out", int'(cmp_out), 0);
        chk("R1 pin_oe", int'(pin_oe), 0);
        rd(4'd0, 8'h20, "R1 ctrl");
        rd16(4'd1, 16'h0000, "R1 count");
        rd16(4'd3, 16'hFFFF, "R1 limit");
        rd(4'd5, 8'h00, "R1 ch0 setup");
        rd(4'd8, 8'h00, "R1 ch1 setup");

        // R2 prescaler ratios over 200 edges
        clear_cnt(3'd0); run(200, 3'd0); rd16(4'd1, 16'd200, "R2 div1");
        clear_cnt(3'd1); run(200, 3'd1); rd16(4'd1, 16'd100, "R2 div2");
        clear_cnt(3'd3); run(200, 3'd3); rd16(4'd1, 16'd25, "R2 div8");
        clear_cnt(3'd7); run(200, 3'd7); rd16(4'd1, 16'd3, "R2 sel7 as div64");

        // R3 / R13 halted count is stable and reads do not disturb it
        rd16(4'd1, 16'd3, "R13 reread");
        repeat (10) @(negedge clk);
        rd16(4'd1, 16'd3, "R3 halted");

        // R4 clear zeroes count and prescaler
        clear_cnt(3'd1); run(21, 3'd1); rd16(4'd1, 16'd10, "R4 before clear");
        clear_cnt(3'd1);
        rd16(4'd1, 16'd0, "R4 count cleared");
        rd(4'd0, 8'h21, "R4 clear bit reads 0");
        run(3, 3'd1); rd16(4'd1, 16'd1, "R4 prescaler cleared");

        // R6 buffered high byte
        wr(4'd3, 8'h00);
        rd(4'd3, 8'hFF, "R6 high byte held");
        wr(4'd4, 8'h05);
        rd16(4'd3, 16'h0005, "R6 limit committed");

        // R5 wrap at limit, R10 flag clear protocol
        clear_cnt(3'd0); run(9, 3'd0);
        rd16(4'd1, 16'd3, "R5 wrapped count");
        wr(4'd0, 8'h20);
        rd(4'd0, 8'hA0, "R10 flag kept without read");
        wr(4'd0, 8'h20);
        rd(4'd0, 8'h20, "R10 flag cleared after read");

        // R11 interrupt
        g_ie = 1'b1;
        clear_cnt(3'd0); run(6, 3'd0);
        chk("R11 irq on overflow", int'(irq), 1);
        rd(4'd0, 8'hE0, "R11 ctrl");
        wr(4'd0, 8'h60);
        chk("R11 irq after clear", int'(irq), 0);
        g_ie = 1'b0;
        clear_cnt(3'd0);

        // R8 / R12 compare on channel 0
        set_limit(16'hFFFF);
        wr(4'd6, 8'h00); wr(4'd7, 8'h03);
        wr(4'd5, 8'h28);
        chk("R12 oe compare", int'(pin_oe[0]), 1);
        clear_cnt(3'd0); run(5, 3'd0);
        chk("R8 toggle on match", int'(cmp_out[0]), 1);
        rd(4'd5, 8'hA8, "R8 compare flag");
        wr(4'd5, 8'h28);
        rd(4'd5, 8'h28, "R10 channel flag cleared");
        wr(4'd5, 8'h30);
        clear_cnt(3'd0); run(5, 3'd0);
        chk("R8 drive low on match", int'(cmp_out[0]), 0);
        wr(4'd5, 8'h32);
        chk("R9 force high", int'(cmp_out[0]), 1);
        wr(4'd5, 8'h30);
        chk("R9 force released", int'(cmp_out[0]), 0);
        rd(4'd5, 8'hB0, "R10 channel flag kept without read");
        wr(4'd5, 8'h38);
        clear_cnt(3'd0); run(5, 3'd0);
        chk("R8 drive high on match", int'(cmp_out[0]), 1);
        wr(4'd5, 8'h20);
        chk("R12 oe off with action 00", int'(pin_oe[0]), 0);

        // R9 toggle on wrap
        set_limit(16'h0003);
        wr(4'd6, 8'hFF); wr(4'd7, 8'hFF);
        wr(4'd5, 8'h2C);
        clear_cnt(3'd0); run(5, 3'd0);
        chk("R9 first wrap toggle", int'(cmp_out[0]), 0);
        run(4, 3'd0);
        chk("R9 second wrap toggle", int'(cmp_out[0]), 1);
        set_limit(16'hFFFF);

        // R7 capture on channel 1
        wr(4'd8, 8'h08);
        chk("R12 oe capture", int'(pin_oe[1]), 0);
        clear_cnt(3'd0); run(40, 3'd0);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(4'd9, 16'd40, "R7 rising capture");
        rd(4'd8, 8'h88, "R7 capture flag");
        wr(4'd8, 8'h08);
        run(10, 3'd0);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(4'd9, 16'd40, "R7 falling ignored");
        rd(4'd8, 8'h08, "R7 no flag on ignored edge");
        wr(4'd8, 8'h18);
        run(10, 3'd0);
        @(negedge clk); cap_in[1] = 1'b1;
        repeat (5) @(negedge clk);
        rd16(4'd9, 16'd60, "R7 both-edge rising");
        rd(4'd8, 8'h98, "R7 both-edge flag");
        wr(4'd8, 8'h10);
        run(5, 3'd0);
        @(negedge clk); cap_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        rd16(4'd9, 16'd65, "R7 falling capture");
        rd(4'd8, 8'h90, "R7 falling flag");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule